// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block sits beside the instruction decoder of a small 8-bit processor core. It keeps the two maskable-interrupt enable flags: the live flag, which gates requests, and the saved copy, which holds the live flag's value while a non-maskable interrupt is serviced. At every instruction boundary it decides whether a non-maskable or a maskable request is accepted. It also tracks the halted state, in which the core keeps fetching the same halt opcode as a 4-T-state no-op until an interrupt arrives.

The decoder drives single-cycle strobes for the enable, disable and halt instructions. Each strobe is asserted in the same cycle as `instr_done` for the instruction that causes it. The request lines pass through a synchronizer chain of `SYNC_STAGES` flops before use. The maskable request is level-sensitive. The non-maskable request is edge-detected and latched until it is taken. Pushing the return address, making the vector and handling interrupt modes belong to the core. This block supplies only the accept and hold decisions.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After reset, `iff1`, `iff2`, `halted`, `hold_pc`, `take_int` and `take_nmi` are all 0.
- R2: `ei_stb`, `di_stb` and `halt_stb` act only in a cycle where `instr_done` is 1. An enable sets both flags, and a disable clears both, from the next cycle.
- R3: At the boundary of the enable instruction itself, a maskable request is not accepted even when `iff1` was already 1. At the next boundary it is accepted.
- R4: A maskable request is accepted only at a boundary where `iff1` is 1 and the completing instruction is neither an enable nor a disable. Accepting it clears both flags.
- R5: A rising edge of `nmi_req` is latched until it is taken. A level held high after being taken does not cause a second acceptance. A new rising edge does.
- R6: A pending non-maskable request is accepted at any boundary, including the enable instruction's own boundary. Accepting it clears `iff1` and leaves `iff2` at the value the completing instruction gives it.
- R7: When both requests can be accepted at one boundary, only the non-maskable one is accepted. `take_int` and `take_nmi` are never both 1.
- R8: A halt boundary with no acceptance raises `hold_pc` in that cycle and `halted` from the next cycle. Later boundaries without an acceptance keep both high.
- R9: Accepting either interrupt clears `halted` from the next cycle and drops `hold_pc` in the accepting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_done | input | 1 | An instruction (or a halt repeat) completes this cycle |
| ei_stb | input | 1 | Completing instruction is interrupt-enable |
| di_stb | input | 1 | Completing instruction is interrupt-disable |
| halt_stb | input | 1 | Completing instruction is halt |
| int_req | input | 1 | Maskable interrupt request, level, asynchronous |
| nmi_req | input | 1 | Non-maskable interrupt request, edge, asynchronous |
| take_int | output | 1 | Maskable interrupt accepted at this boundary |
| take_nmi | output | 1 | Non-maskable interrupt accepted at this boundary |
| halted | output | 1 | Core is in the halted state |
| hold_pc | output | 1 | Keep the program counter so the halt opcode is fetched again |
| iff1 | output | 1 | Live maskable enable flag |
| iff2 | output | 1 | Saved copy of the enable flag |

## Verification
The in-line assertions check on every cycle that the two acceptances are exclusive, that each acceptance leaves the flags and the halted state as required, that an enable or disable boundary updates both flags, and that a synchronized edge always leaves a pending request. Only the directed scenarios can show the one-instruction hold-off after an enable, the single acceptance of a held non-maskable level, and the exit from halt by a late request after several repeat boundaries. These behaviours depend on sequences of boundaries rather than on one cycle.

// File: rtl/irqhc_pkg.sv
// Shared types for the interrupt enable / halt controller.
package irqhc_pkg;
    // Decision taken at an instruction boundary.
    typedef enum logic [1:0] {
        GRANT_NONE = 2'd0,
        GRANT_INT  = 2'd1,
        GRANT_NMI  = 2'd2
    } grant_e;
endpackage

// File: rtl/irq_sync.sv
// Synchronizer chain for an asynchronous request line.
// Assumes: STAGES == 0 means the input is already synchronous.
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            // Shift the request through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/nmi_latch.sv
// Edge detector and pending latch for the non-maskable request.
// Assumes: nmi_s is already synchronous; take clears the pending bit
// unless a new edge arrives in the same cycle.
module nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_s,
    input  logic take,
    output logic pending
);
    logic nmi_q;
    logic rise;

    assign rise = nmi_s & ~nmi_q;

    // Remember the previous level and keep a rising edge until it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            nmi_q <= nmi_s;
            if (rise)      pending <= 1'b1;
            else if (take) pending <= 1'b0;
        end
    end

    // R5
    nmi_edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pending);
endmodule

// File: rtl/iff_regs.sv
// The two maskable enable flags.
// Assumes: ei_now/di_now are already qualified by the instruction boundary.
// The instruction's effect applies first and the acceptance second.
module iff_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic ei_now,
    input  logic di_now,
    input  logic take_int,
    input  logic take_nmi,
    output logic iff1,
    output logic iff2
);
    logic f1_after_instr, f2_after_instr;

    // Effect of the completing instruction on both flags.
    always_comb begin
        f1_after_instr = iff1;
        f2_after_instr = iff2;
        if (ei_now) begin
            f1_after_instr = 1'b1;
            f2_after_instr = 1'b1;
        end else if (di_now) begin
            f1_after_instr = 1'b0;
            f2_after_instr = 1'b0;
        end
    end

    // Register the flags; an acceptance overrides the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take_int) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take_nmi) begin
            iff1 <= 1'b0;
            iff2 <= f2_after_instr;
        end else begin
            iff1 <= f1_after_instr;
            iff2 <= f2_after_instr;
        end
    end

    // R4
    int_clears_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> (!iff1 && !iff2));
    // R6
    nmi_clears_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> (!iff1 && (iff2 == ($past(ei_now) | ($past(iff2) & ~$past(di_now))))));
    // R2
    ei_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_now && !take_int && !take_nmi) |=> (iff1 && iff2));
    // R2
    di_clears_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        di_now |=> (!iff1 && !iff2));
endmodule

// File: rtl/halt_tracker.sv
// Halted state and program-counter hold.
// Assumes: halt_now is qualified by the boundary; take_any is the acceptance.
module halt_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_now,
    input  logic take_any,
    output logic halted,
    output logic hold_pc
);
    // Enter on a halt boundary and leave on any acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)        halted <= 1'b0;
        else if (take_any) halted <= 1'b0;
        else if (halt_now) halted <= 1'b1;
    end

    // Hold the PC from the halt boundary on, except when an interrupt is taken.
    assign hold_pc = (halted | halt_now) & ~take_any;

    // R9
    take_leaves_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_any |=> !halted);
    // R8
    halt_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_now && !take_any) |=> halted);
endmodule

// File: rtl/irq_halt_ctrl.sv
// Interrupt enable and halt controller: it decides at each instruction
// boundary whether a non-maskable or a maskable interrupt is accepted, and
// keeps the halted state.
// Assumes: strobes are asserted in the same cycle as instr_done.
module irq_halt_ctrl
    import irqhc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_done,
    input  logic ei_stb,
    input  logic di_stb,
    input  logic halt_stb,
    input  logic int_req,
    input  logic nmi_req,
    output logic take_int,
    output logic take_nmi,
    output logic halted,
    output logic hold_pc,
    output logic iff1,
    output logic iff2
);
    logic   int_s, nmi_s, nmi_pend;
    logic   ei_now, di_now, halt_now;
    grant_e grant;

    assign ei_now   = instr_done & ei_stb;
    assign di_now   = instr_done & di_stb;
    assign halt_now = instr_done & halt_stb;

    irq_sync #(.STAGES(SYNC_STAGES)) u_int_sync (
        .clk(clk), .rst_n(rst_n), .d(int_req), .q(int_s));
    irq_sync #(.STAGES(SYNC_STAGES)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .d(nmi_req), .q(nmi_s));

    nmi_latch u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi_s(nmi_s), .take(take_nmi), .pending(nmi_pend));

    // Boundary arbitration: a non-maskable request wins, and a maskable one waits one instruction after an enable.
    always_comb begin
        grant = GRANT_NONE;
        if (instr_done) begin
            if (nmi_pend)
                grant = GRANT_NMI;
            else if (int_s && iff1 && !ei_stb && !di_stb)
                grant = GRANT_INT;
        end
    end

    assign take_nmi = (grant == GRANT_NMI);
    assign take_int = (grant == GRANT_INT);

    iff_regs u_iff (
        .clk(clk), .rst_n(rst_n), .ei_now(ei_now), .di_now(di_now),
        .take_int(take_int), .take_nmi(take_nmi), .iff1(iff1), .iff2(iff2));

    halt_tracker u_halt (
        .clk(clk), .rst_n(rst_n), .halt_now(halt_now),
        .take_any(take_int | take_nmi), .halted(halted), .hold_pc(hold_pc));

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_int, take_nmi}));
    // R3
    no_int_at_ei_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ei_now |-> !take_int);
    // R8
    halt_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !take_int && !take_nmi) |-> hold_pc);
endmodule

// File: tb/tb_irq_halt_ctrl.sv
module tb_irq_halt_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_done = 0, ei_stb = 0, di_stb = 0, halt_stb = 0, int_req = 0, nmi_req = 0;
    logic take_int, take_nmi, halted, hold_pc, iff1, iff2;
    int   n_run = 0, n_fail = 0;
    logic ti, tn, hp;

    always #10 clk = ~clk;

    irq_halt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ei_stb(ei_stb),
        .di_stb(di_stb), .halt_stb(halt_stb), .int_req(int_req), .nmi_req(nmi_req),
        .take_int(take_int), .take_nmi(take_nmi), .halted(halted), .hold_pc(hold_pc),
        .iff1(iff1), .iff2(iff2));

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // One boundary; the acceptance outputs are captured mid-cycle.
    task automatic bnd(input logic e, input logic d, input logic h,
                       output logic t_i, output logic t_n, output logic h_p);
        @(negedge clk);
        instr_done = 1; ei_stb = e; di_stb = d; halt_stb = h;
        #2;
        t_i = take_int; t_n = take_nmi; h_p = hold_pc;
        @(posedge clk); #1;
        instr_done = 0; ei_stb = 0; di_stb = 0; halt_stb = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset;
        int_req = 0; nmi_req = 0;
        @(negedge clk); rst_n = 0;
        idle(3);
        rst_n = 1;
        idle(1);
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 iff1", iff1, 0); chk("R1 iff2", iff2, 0);
        chk("R1 halted", halted, 0); chk("R1 hold_pc", hold_pc, 0);
        chk("R1 take_int", take_int, 0); chk("R1 take_nmi", take_nmi, 0);
    endtask

    task automatic t_ei_holdoff;
        do_reset();
        int_req = 1; idle(4);
        bnd(0, 0, 0, ti, tn, hp);
        chk("R4 gated by iff1", ti, 0);
        // R2: strobe without boundary has no effect
        @(negedge clk); ei_stb = 1; @(negedge clk); ei_stb = 0;
        chk("R2 ei without boundary", iff1, 0);
        bnd(1, 0, 0, ti, tn, hp);
        chk("R3 no int at ei", ti, 0);
        @(negedge clk);
        chk("R2 ei sets iff1", iff1, 1); chk("R2 ei sets iff2", iff2, 1);
        bnd(1, 0, 0, ti, tn, hp);
        chk("R3 ei with iff1 set", ti, 0);
        bnd(0, 0, 0, ti, tn, hp);
        chk("R3 int next boundary", ti, 1);
        @(negedge clk);
        chk("R4 clears iff1", iff1, 0); chk("R4 clears iff2", iff2, 0);
        int_req = 0;
    endtask

    task automatic t_di;
        do_reset();
        bnd(1, 0, 0, ti, tn, hp);
        int_req = 1; idle(4);
        bnd(0, 1, 0, ti, tn, hp);
        chk("R4 no int at di", ti, 0);
        @(negedge clk);
        chk("R2 di clears iff1", iff1, 0); chk("R2 di clears iff2", iff2, 0);
        bnd(0, 0, 0, ti, tn, hp);
        chk("R4 none after di", ti, 0);
        int_req = 0;
    endtask

    task automatic t_nmi;
        do_reset();
        nmi_req = 1; idle(5);
        bnd(1, 0, 0, ti, tn, hp);
        chk("R6 nmi at ei", tn, 1);
        @(negedge clk);
        chk("R6 iff1 cleared", iff1, 0); chk("R6 iff2 kept", iff2, 1);
        bnd(0, 0, 0, ti, tn, hp);
        chk("R5 held level not retaken", tn, 0);
        nmi_req = 0; idle(4); nmi_req = 1; idle(5);
        bnd(0, 0, 0, ti, tn, hp);
        chk("R5 new edge taken", tn, 1);
        nmi_req = 0;
    endtask

    task automatic t_priority;
        do_reset();
        bnd(1, 0, 0, ti, tn, hp);
        int_req = 1; nmi_req = 1; idle(5);
        bnd(0, 0, 0, ti, tn, hp);
        chk("R7 nmi wins", tn, 1); chk("R7 int not taken", ti, 0);
        bnd(1, 0, 0, ti, tn, hp);
        bnd(0, 0, 0, ti, tn, hp);
        chk("R4 int after nmi done", ti, 1);
        int_req = 0; nmi_req = 0;
    endtask

    task automatic t_halt;
        do_reset();
        bnd(1, 0, 0, ti, tn, hp);
        bnd(0, 0, 1, ti, tn, hp);
        chk("R8 hold at halt", hp, 1);
        @(negedge clk);
        chk("R8 halted", halted, 1);
        for (int k = 0; k < 3; k++) begin
            bnd(0, 0, 1, ti, tn, hp);
            chk("R8 repeat holds", hp, 1);
        end
        int_req = 1; idle(4);
        chk("R8 still halted", halted, 1);
        bnd(0, 0, 1, ti, tn, hp);
        chk("R9 int taken in halt", ti, 1); chk("R9 hold dropped", hp, 0);
        @(negedge clk);
        chk("R9 halted cleared", halted, 0);
        int_req = 0;
    endtask

    initial begin
        t_reset();
        t_ei_holdoff();
        t_di();
        t_nmi();
        t_priority();
        t_halt();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule